// File: doc/BRIEF.md
# Timer Interrupt Flag and Enable Controller

This block keeps the pending-event flags and the per-source enables for eight timer interrupt sources: compare and overflow for three timers, a second compare channel and an input-capture event for the middle timer. Single-cycle strobes from the timers set the flags. Software reaches two 8-bit registers, one holding flags and one holding enables, through a one-cycle register write port and a combinational read port. Each flag is cleared either by software writing a one to its position or by an acknowledge pulse from the interrupt controller when that source's vector is taken.

One interrupt request per source leaves the block. A request is high only while the global interrupt enable, the source's enable bit and its flag are all one. For the third timer running in dual-slope (up/down) PWM, a small detector watches the counter's direction and count. It raises that timer's overflow event when the count turns from falling to rising at zero, rather than taking the overflow strobe.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset, the flag register, the enable register and every request output are zero.
- R2: A one on `evt_set[i]` in a cycle sets flag bit i at the next clock edge. The bit positions are: 7 timer2 compare, 6 timer2 overflow, 5 timer1 capture, 4 timer1 compare A, 3 timer1 compare B, 2 timer1 overflow, 1 timer0 compare, 0 timer0 overflow. Flags and enables use the same positions.
- R3: A write with `reg_sel`=0 clears every flag bit whose write-data bit is one. Flag bits whose write-data bit is zero keep their value.
- R4: A one on `ack[i]` clears flag bit i at the next clock edge.
- R5: A write with `reg_sel`=1 loads all 8 enable bits from the write data. `reg_rdata` shows the flags when `reg_sel`=0 and the enables when `reg_sel`=1, combinationally.
- R6: `irq[i]` is one exactly when `gie`, enable bit i and flag bit i are all one. It is combinational from the registers, so it follows a flag change in the cycle after the causing event.
- R7: When a set strobe and a clear, whether from software or from an acknowledge, reach the same flag in the same cycle, the flag ends up set.
- R8: While `t2_updn_mode` is 1, flag bit 6 is set one edge after a cycle in which `t2_dir_dn` is 0, `t2_cnt` is zero and `t2_dir_dn` was 1 in the previous cycle. In that mode `evt_set[6]` has no effect. While the mode is 0, the detector sets nothing.
- R9: In up/down mode, a direction reversal at a nonzero count does not set flag bit 6. A turn from rising to falling at zero does not set it either.
- R10: A write to the enable register leaves the flags unchanged. A write to the flag register leaves the enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_sel | input | 1 | Register select: 0 flags, 1 enables |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| evt_set | input | 8 | Per-source event strobes |
| ack | input | 8 | Per-source vector-taken pulses |
| gie | input | 1 | Global interrupt enable |
| t2_updn_mode | input | 1 | Timer2 is in up/down PWM |
| t2_dir_dn | input | 1 | Timer2 is counting down |
| t2_cnt | input | 8 | Timer2 count value |
| irq | output | 8 | Per-source interrupt requests |

## Verification
Flag and enable updates from strobes, writes and acknowledges appear one edge after the driving cycle. The bench drives each stimulus at a falling edge, returns the inputs to idle at the next falling edge, and only then reads both registers and the requests. Requests are combinational from state, so they are checked in that same low phase. The up/down detector needs one cycle to register the falling direction and a second cycle with the rising direction at zero. The flag is due one edge after that second cycle, and the bench reads it there.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int SRC_N       = 8;
  localparam int IDX_T2_CMP  = 7;
  localparam int IDX_T2_OVF  = 6;
  localparam int IDX_T1_CAP  = 5;
  localparam int IDX_T1_CMPA = 4;
  localparam int IDX_T1_CMPB = 3;
  localparam int IDX_T1_OVF  = 2;
  localparam int IDX_T0_CMP  = 1;
  localparam int IDX_T0_OVF  = 0;

  // next flag value: a set strobe beats any clear
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  // request gating for one source
  function automatic logic req_gate(logic g, logic e, logic f);
    return g & e & f;
  endfunction

  // direction reversal at bottom: falling last cycle, rising now, count zero
  function automatic logic bottom_turn(logic was_dn, logic is_dn, logic at_zero);
    return was_dn & ~is_dn & at_zero;
  endfunction
endpackage

// File: rtl/tmr_irq_flag_cell.sv
module tmr_irq_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  import tmr_irq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= flag_next(flag_o, set_i, clr_i);
  end
endmodule

// File: rtl/tmr_irq_en_reg.sv
module tmr_irq_en_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_o <= '0;
    else if (we_i) en_o <= wdata_i;
  end
endmodule

// File: rtl/tmr_irq_updn_det.sv
module tmr_irq_updn_det #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic             dir_dn_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             evt_o
);
  import tmr_irq_pkg::*;

  logic dir_dn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_dn_q <= 1'b0;
    else        dir_dn_q <= dir_dn_i;
  end

  assign evt_o = mode_i & bottom_turn(dir_dn_q, dir_dn_i, (cnt_i == '0));
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int SRC_N = tmr_irq_pkg::SRC_N,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [SRC_N-1:0] reg_wdata,
  output logic [SRC_N-1:0] reg_rdata,
  input  logic [SRC_N-1:0] evt_set,
  input  logic [SRC_N-1:0] ack,
  input  logic             gie,
  input  logic             t2_updn_mode,
  input  logic             t2_dir_dn,
  input  logic [CNT_W-1:0] t2_cnt,
  output logic [SRC_N-1:0] irq
);
  import tmr_irq_pkg::*;

  localparam int OVF_BIT = IDX_T2_OVF;

  logic             flag_we;
  logic             en_we;
  logic             updn_evt;
  logic [SRC_N-1:0] set_vec;
  logic [SRC_N-1:0] clr_vec;
  logic [SRC_N-1:0] flags;
  logic [SRC_N-1:0] en_q;

  assign flag_we = reg_wr & ~reg_sel;
  assign en_we   = reg_wr &  reg_sel;

  tmr_irq_updn_det #(.CNT_W(CNT_W)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (t2_updn_mode),
    .dir_dn_i (t2_dir_dn),
    .cnt_i    (t2_cnt),
    .evt_o    (updn_evt)
  );

  tmr_irq_en_reg #(.W(SRC_N)) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (en_we),
    .wdata_i (reg_wdata),
    .en_o    (en_q)
  );

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    if (i == OVF_BIT) begin : g_ovf_sel
      assign set_vec[i] = t2_updn_mode ? updn_evt : evt_set[i];
    end else begin : g_plain
      assign set_vec[i] = evt_set[i];
    end

    assign clr_vec[i] = (flag_we & reg_wdata[i]) | ack[i];

    tmr_irq_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec[i]),
      .clr_i  (clr_vec[i]),
      .flag_o (flags[i])
    );

    assign irq[i] = req_gate(gie, en_q[i], flags[i]);
  end

  assign reg_rdata = reg_sel ? en_q : flags;
endmodule

// File: rtl/tmr_irq_ctrl_chk.sv
module tmr_irq_ctrl_chk #(
  parameter int SRC_N = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_sel,
  input logic [SRC_N-1:0] reg_wdata,
  input logic [SRC_N-1:0] ack,
  input logic             gie,
  input logic             t2_updn_mode,
  input logic [SRC_N-1:0] irq,
  input logic [SRC_N-1:0] set_vec,
  input logic [SRC_N-1:0] flags,
  input logic [SRC_N-1:0] en,
  input logic             updn_evt
);
  import tmr_irq_pkg::*;

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

  assert_swclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && ((reg_wdata & ~set_vec) != '0))
      |=> ((flags & $past(reg_wdata & ~set_vec)) == '0));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_wr && !reg_sel) && (ack == '0) && (set_vec == '0)) |=> $stable(flags));

  assert_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack & ~set_vec) != '0) |=> ((flags & $past(ack & ~set_vec)) == '0));

  assert_en_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel) |=> (en == $past(reg_wdata)));

  assert_irq_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~flags) == '0));

  assert_irq_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~en) == '0));

  assert_irq_gie_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (irq == '0));

  assert_updn_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    updn_evt |=> flags[IDX_T2_OVF]);

  assert_updn_ign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (t2_updn_mode && !updn_evt && !flags[IDX_T2_OVF]) |=> !flags[IDX_T2_OVF]);

  assert_en_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_sel) |=> $stable(en));
endmodule

bind tmr_irq_ctrl tmr_irq_ctrl_chk #(.SRC_N(SRC_N)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_sel      (reg_sel),
  .reg_wdata    (reg_wdata),
  .ack          (ack),
  .gie          (gie),
  .t2_updn_mode (t2_updn_mode),
  .irq          (irq),
  .set_vec      (set_vec),
  .flags        (flags),
  .en           (en_q),
  .updn_evt     (updn_evt)
);

// File: tb/tmr_irq_ctrl_tb.sv
module tmr_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] evt_set = '0;
  logic [7:0] ack = '0;
  logic       gie = 1'b0;
  logic       t2_updn_mode = 1'b0;
  logic       t2_dir_dn = 1'b0;
  logic [7:0] t2_cnt = '0;
  logic [7:0] irq;

  int total = 0;
  int bad = 0;
  logic [7:0] rd_flags, rd_en;

  always #4 clk = ~clk;

  tmr_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
    .ack(ack), .gie(gie), .t2_updn_mode(t2_updn_mode), .t2_dir_dn(t2_dir_dn),
    .t2_cnt(t2_cnt), .irq(irq)
  );

  // row: wr, sel, wdata, evt, ack, gie, exp_flags, exp_en, exp_irq
  localparam int NROW = 12;
  localparam logic [50:0] TBL [NROW] = '{
    {1'b1,1'b1,8'hFF,8'h00,8'h00,1'b0,8'h00,8'hFF,8'h00}, // R5 enable write
    {1'b0,1'b0,8'h00,8'h81,8'h00,1'b0,8'h81,8'hFF,8'h00}, // R2 set, R6 gie off
    {1'b0,1'b0,8'h00,8'h00,8'h00,1'b1,8'h81,8'hFF,8'h81}, // R6 gie on
    {1'b1,1'b0,8'h00,8'h00,8'h00,1'b1,8'h81,8'hFF,8'h81}, // R3 zeros keep
    {1'b1,1'b0,8'h01,8'h00,8'h00,1'b1,8'h80,8'hFF,8'h80}, // R3 one clears
    {1'b0,1'b0,8'h00,8'h00,8'h80,1'b1,8'h00,8'hFF,8'h00}, // R4 ack clears
    {1'b0,1'b0,8'h00,8'h7E,8'h00,1'b1,8'h7E,8'hFF,8'h7E}, // R2 other bits
    {1'b1,1'b1,8'h0F,8'h00,8'h00,1'b1,8'h7E,8'h0F,8'h0E}, // R10 en write
    {1'b1,1'b0,8'h0E,8'h02,8'h00,1'b1,8'h72,8'h0F,8'h02}, // R7 set vs sw clear
    {1'b0,1'b0,8'h00,8'h10,8'h70,1'b1,8'h12,8'h0F,8'h02}, // R7 set vs ack
    {1'b1,1'b1,8'h00,8'h00,8'h00,1'b1,8'h12,8'h00,8'h00}, // R6 enables off
    {1'b1,1'b0,8'hFF,8'h00,8'h00,1'b1,8'h00,8'h00,8'h00}  // R3 clear all
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic read_regs();
    reg_sel = 1'b0;
    #1 rd_flags = reg_rdata;
    reg_sel = 1'b1;
    #1 rd_en = reg_rdata;
    reg_sel = 1'b0;
  endtask

  // drive one cycle of stimulus, then return to idle; result due after one edge
  task automatic step(input logic wr, input logic sel, input logic [7:0] wd,
                      input logic [7:0] ev, input logic [7:0] ak);
    @(negedge clk);
    reg_wr = wr; reg_sel = sel; reg_wdata = wd; evt_set = ev; ack = ak;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0; evt_set = '0; ack = '0;
    read_regs();
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    read_regs();
    check("R1", "flags at reset", rd_flags, 8'h00);
    check("R1", "enables at reset", rd_en, 8'h00);
    check("R1", "irq at reset", irq, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    read_regs();
    check("R1", "flags after release", rd_flags, 8'h00);

    for (int r = 0; r < NROW; r++) begin
      logic [50:0] row;
      row = TBL[r];
      gie = row[24];
      step(row[50], row[49], row[48:41], row[40:33], row[32:25]);
      check("R2-tbl", $sformatf("row %0d flags", r), rd_flags, row[23:16]);
      check("R5-tbl", $sformatf("row %0d enables", r), rd_en, row[15:8]);
      check("R6-tbl", $sformatf("row %0d irq", r), irq, row[7:0]);
    end

    // up/down detector, R8 and R9
    gie = 1'b1;
    step(1'b1, 1'b1, 8'hFF, 8'h00, 8'h00);
    @(negedge clk); t2_updn_mode = 1'b1; t2_dir_dn = 1'b1; t2_cnt = 8'd3;
    @(negedge clk); t2_cnt = 8'd0;
    @(negedge clk); t2_dir_dn = 1'b0; t2_cnt = 8'd0;
    @(negedge clk); t2_cnt = 8'd1;
    read_regs();
    check("R8", "bottom turn sets ovf flag", rd_flags, 8'h40);
    check("R8", "bottom turn irq", irq, 8'h40);
    step(1'b1, 1'b0, 8'h40, 8'h00, 8'h00);
    check("R8", "ovf flag cleared", rd_flags, 8'h00);
    step(1'b0, 1'b0, 8'h00, 8'hC0, 8'h00);
    check("R8", "ovf strobe ignored in updn", rd_flags, 8'h80);

    @(negedge clk); t2_dir_dn = 1'b1; t2_cnt = 8'd5;
    @(negedge clk); t2_dir_dn = 1'b0;
    @(negedge clk); t2_cnt = 8'd6;
    @(negedge clk); read_regs();
    check("R9", "turn at nonzero count", rd_flags, 8'h80);

    @(negedge clk); t2_dir_dn = 1'b0; t2_cnt = 8'd0;
    @(negedge clk); t2_dir_dn = 1'b1;
    @(negedge clk); t2_cnt = 8'd1;
    @(negedge clk); read_regs();
    check("R9", "top-style turn at zero", rd_flags, 8'h80);

    @(negedge clk); t2_updn_mode = 1'b0; t2_dir_dn = 1'b1; t2_cnt = 8'd0;
    @(negedge clk); t2_dir_dn = 1'b0;
    @(negedge clk); t2_cnt = 8'd1;
    @(negedge clk); read_regs();
    check("R8", "detector idle outside updn", rd_flags, 8'h80);

    step(1'b0, 1'b0, 8'h00, 8'h40, 8'h00);
    check("R8", "ovf strobe used outside updn", rd_flags, 8'hC0);

    step(1'b1, 1'b1, 8'h00, 8'h00, 8'h00);
    check("R10", "enable write keeps flags", rd_flags, 8'hC0);
    step(1'b1, 1'b0, 8'h00, 8'h00, 8'h00);
    check("R3", "zero write keeps pending", rd_flags, 8'hC0);
    step(1'b1, 1'b0, 8'hFF, 8'h00, 8'h00);
    check("R10", "flag write keeps enables", rd_en, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule